// File: doc/BRIEF.md
# Input Enable Sample Qualifier

This block sits between a pair of wideband converter input ports and one receive channel. Each port carries a two's-complement mantissa, an unsigned exponent and an enable line. A select bit picks which port feeds the channel. A two-bit mode then decides how the chosen enable line is read: as a blanking control, as a level qualifier, or as an edge qualifier on either its rising or its falling transition.

On every clock the block presents a registered sample to the channel, which may be forced to zero. It also raises a strobe that tells the downstream oscillator whether to step its phase, and a one-clock flag that marks a freshly latched sample. The back-end filters are assumed to run on every clock, whatever the mode. The qualifier therefore only decides what data they see and whether the oscillator phase moves.

All outputs change one clock after the inputs that cause them, that is, at the clock edge that captures those inputs.

Top module: `iqq_input_qualifier`

## Requirements
- R1: When `port_b_sel` is 1, mantissa, exponent and enable are taken from port B; when it is 0 they are taken from port A.
- R2: Mode 0 (blanking): a sample captured with enable low appears as mantissa 0 and exponent 0; a sample captured with enable high is passed unchanged.
- R3: Mode 0: `phase_step` and `new_sample` are both 1 after every clock, with or without enable.
- R4: Mode 1 (level): every clock edge that sees enable high latches the input, and `phase_step` and `new_sample` are 1 in the following cycle.
- R5: Mode 1: a clock edge that sees enable low leaves the output sample unchanged, and `phase_step` and `new_sample` are 0 in the following cycle.
- R6: Mode 2 (rising): only the first clock edge at which enable is 1 after having been 0 on the previous edge latches a sample. The `new_sample` flag is a one-cycle pulse.
- R7: Mode 3 (falling): only the first clock edge at which enable is 0 after having been 1 on the previous edge latches a sample. The `new_sample` flag is a one-cycle pulse.
- R8: In modes 2 and 3, `phase_step` is 1 exactly in the cycles where `new_sample` is 1.
- R9: In modes 2 and 3, the last latched mantissa and exponent are held on the outputs between qualifying edges.
- R10: A synchronous active-high reset clears all outputs to 0 and clears the stored previous enable. After reset, mode 2 treats enable high on the first edge as a rising transition, and mode 3 needs enable to be seen high before any falling transition counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| port_b_sel | input | 1 | 1 selects port B, 0 selects port A |
| qual_mode | input | 2 | 0 blank, 1 level, 2 rising edge, 3 falling edge |
| a_mant | input | MANT_W | Port A mantissa, two's complement |
| a_exp | input | EXP_W | Port A exponent, unsigned |
| a_en | input | 1 | Port A enable line |
| b_mant | input | MANT_W | Port B mantissa, two's complement |
| b_exp | input | EXP_W | Port B exponent, unsigned |
| b_en | input | 1 | Port B enable line |
| smp_mant | output | MANT_W | Sample mantissa delivered to the channel |
| smp_exp | output | EXP_W | Sample exponent delivered to the channel |
| phase_step | output | 1 | Oscillator phase advance strobe |
| new_sample | output | 1 | One-cycle flag for a newly latched sample |

## Verification
The bench first targets the edge modes. It drives enable patterns that hold high or low for several clocks, which catches a qualifier that fires on a level instead of once per transition. It also catches a design that updates the data on a non-qualifying clock, or that steps the oscillator in a gap. In mode 1 the bench checks the held sample and the silent strobes on low enable, which exposes a design that confuses level latching with blanking. In mode 0 it checks that both strobes stay up through gaps, so a design that stops the phase during blanking would drift. Port swaps with different data on each port and the first edges after reset complete the set: a design that fails to clear its stored enable would miss, or invent, the first rising transition.

// File: rtl/iqq_pkg.sv
package iqq_pkg;

  typedef enum logic [1:0] {
    QM_BLANK = 2'b00,
    QM_LEVEL = 2'b01,
    QM_RISE  = 2'b10,
    QM_FALL  = 2'b11
  } qual_mode_e;

  function automatic logic is_edge_mode(input qual_mode_e m);
    return (m == QM_RISE) || (m == QM_FALL);
  endfunction

endpackage

// File: rtl/iqq_port_mux.sv
module iqq_port_mux #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3,
  parameter int PORTS  = 2,
  localparam int SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic [PORTS-1:0][MANT_W-1:0] mant_in,
  input  logic [PORTS-1:0][EXP_W-1:0]  exp_in,
  input  logic [PORTS-1:0]             en_in,
  output logic [MANT_W-1:0]            mant_out,
  output logic [EXP_W-1:0]             exp_out,
  output logic                         en_out
);

  logic [PORTS-1:0] hit;

  for (genvar p = 0; p < PORTS; p++) begin : g_dec
    assign hit[p] = (sel == SEL_W'(p));
  end

  always_comb begin
    mant_out = '0;
    exp_out  = '0;
    en_out   = 1'b0;
    for (int p = 0; p < PORTS; p++) begin
      if (hit[p]) begin
        mant_out = mant_in[p];
        exp_out  = exp_in[p];
        en_out   = en_in[p];
      end
    end
  end

endmodule

// File: rtl/iqq_en_qualifier.sv
module iqq_en_qualifier
  import iqq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  qual_mode_e mode,
  input  logic       en,
  output logic       take,
  output logic       blank,
  output logic       step
);

  logic en_prev;

  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b0;
    else     en_prev <= en;
  end

  always_comb begin
    take  = 1'b0;
    blank = 1'b0;
    step  = 1'b0;
    unique case (mode)
      QM_BLANK: begin
        take  = 1'b1;
        blank = !en;
        step  = 1'b1;
      end
      QM_LEVEL: begin
        take = en;
        step = en;
      end
      QM_RISE: begin
        take = en && !en_prev;
        step = take;
      end
      QM_FALL: begin
        take = !en && en_prev;
        step = take;
      end
      default: ;
    endcase
  end

  // R6: a rising qualification cannot repeat on the next clock in mode 2
  a_r6_single_rise: assert property (@(posedge clk) disable iff (rst)
    (mode == QM_RISE && take) |=> (mode != QM_RISE || !take));

  // R7: a falling qualification cannot repeat on the next clock in mode 3
  a_r7_single_fall: assert property (@(posedge clk) disable iff (rst)
    (mode == QM_FALL && take) |=> (mode != QM_FALL || !take));

endmodule

// File: rtl/iqq_sample_reg.sv
module iqq_sample_reg #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              blank,
  input  logic              step,
  input  logic [MANT_W-1:0] mant_in,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [MANT_W-1:0] mant_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic              step_out,
  output logic              new_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mant_out <= '0;
      exp_out  <= '0;
      step_out <= 1'b0;
      new_out  <= 1'b0;
    end else begin
      step_out <= step;
      new_out  <= take;
      if (take) begin
        mant_out <= blank ? '0 : mant_in;
        exp_out  <= blank ? '0 : exp_in;
      end
    end
  end

  // R9: without a take the held sample does not move
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(mant_out) && $stable(exp_out) && !new_out));

endmodule

// File: rtl/iqq_input_qualifier.sv
module iqq_input_qualifier
  import iqq_pkg::*;
#(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_b_sel,
  input  logic [1:0]        qual_mode,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              a_en,
  input  logic [MANT_W-1:0] b_mant,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic              b_en,
  output logic [MANT_W-1:0] smp_mant,
  output logic [EXP_W-1:0]  smp_exp,
  output logic              phase_step,
  output logic              new_sample
);

  localparam int NPORT = 2;

  logic [MANT_W-1:0] sel_mant;
  logic [EXP_W-1:0]  sel_exp;
  logic              sel_en;
  logic              take, blank, step;
  qual_mode_e        mode;

  assign mode = qual_mode_e'(qual_mode);

  iqq_port_mux #(.MANT_W(MANT_W), .EXP_W(EXP_W), .PORTS(NPORT)) u_mux (
    .sel      (port_b_sel),
    .mant_in  ({b_mant, a_mant}),
    .exp_in   ({b_exp, a_exp}),
    .en_in    ({b_en, a_en}),
    .mant_out (sel_mant),
    .exp_out  (sel_exp),
    .en_out   (sel_en)
  );

  iqq_en_qualifier u_qual (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .en    (sel_en),
    .take  (take),
    .blank (blank),
    .step  (step)
  );

  iqq_sample_reg #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .blank    (blank),
    .step     (step),
    .mant_in  (sel_mant),
    .exp_in   (sel_exp),
    .mant_out (smp_mant),
    .exp_out  (smp_exp),
    .step_out (phase_step),
    .new_out  (new_sample)
  );

  // R1: port B data reaches the output in mode 0 when selected and enabled
  a_r1_port_b: assert property (@(posedge clk) disable iff (rst)
    (qual_mode == 2'b00 && port_b_sel && b_en) |=> (smp_mant == $past(b_mant)));

  // R2: blanking forces a zero sample
  a_r2_blank_zero: assert property (@(posedge clk) disable iff (rst)
    (qual_mode == 2'b00 && !sel_en) |=> (smp_mant == '0 && smp_exp == '0));

  // R3: phase keeps stepping through gaps in mode 0
  a_r3_blank_step: assert property (@(posedge clk) disable iff (rst)
    (qual_mode == 2'b00) |=> (phase_step && new_sample));

  // R5: level mode with enable low is silent
  a_r5_level_gap: assert property (@(posedge clk) disable iff (rst)
    (qual_mode == 2'b01 && !sel_en) |=> (!phase_step && !new_sample && $stable(smp_mant)));

  // R8: edge modes step the phase only with a new sample
  a_r8_step_tracks_new: assert property (@(posedge clk) disable iff (rst)
    qual_mode[1] |=> (phase_step == new_sample));

endmodule

// File: tb/tb_iqq_input_qualifier.sv
module tb_iqq_input_qualifier;

  localparam int MW = 14;
  localparam int EW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          port_b_sel = 1'b0;
  logic [1:0]    qual_mode = 2'b10;
  logic [MW-1:0] a_mant = '0, b_mant = '0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic          a_en = 1'b0, b_en = 1'b0;
  logic [MW-1:0] smp_mant;
  logic [EW-1:0] smp_exp;
  logic          phase_step, new_sample;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iqq_input_qualifier #(.MANT_W(MW), .EXP_W(EW)) dut (
    .clk(clk), .rst(rst), .port_b_sel(port_b_sel), .qual_mode(qual_mode),
    .a_mant(a_mant), .a_exp(a_exp), .a_en(a_en),
    .b_mant(b_mant), .b_exp(b_exp), .b_en(b_en),
    .smp_mant(smp_mant), .smp_exp(smp_exp),
    .phase_step(phase_step), .new_sample(new_sample)
  );

  // behavioural reference, updated on each rising edge
  int  m_mant = 0, m_exp = 0;
  bit  m_step = 0, m_new = 0, m_prev = 0;
  int  c_mode = 0;
  bit  c_en = 0, c_port = 0;

  always @(posedge clk) begin
    int mode;
    bit en, got;
    int mi, ei;
    mode = int'(qual_mode);
    en   = port_b_sel ? b_en : a_en;
    mi   = port_b_sel ? int'(b_mant) : int'(a_mant);
    ei   = port_b_sel ? int'(b_exp)  : int'(a_exp);
    if (rst) begin
      m_mant = 0; m_exp = 0; m_step = 0; m_new = 0; m_prev = 0;
    end else begin
      if (mode == 0)      got = 1;
      else if (mode == 1) got = en;
      else if (mode == 2) got = en && !m_prev;
      else                got = !en && m_prev;
      m_new  = got;
      m_step = (mode == 0) ? 1'b1 : got;
      if (got) begin
        m_mant = (mode == 0 && !en) ? 0 : mi;
        m_exp  = (mode == 0 && !en) ? 0 : ei;
      end
      m_prev = en;
    end
    c_mode = mode; c_en = en; c_port = port_b_sel;
  end

  task automatic check(input string tag, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp_v, $time);
    end
  endtask

  task automatic compare_all();
    string dtag, ftag, stag;
    case (c_mode)
      0: begin dtag = "R2"; ftag = "R3"; stag = "R3"; end
      1: begin dtag = c_en ? "R4" : "R5"; ftag = dtag; stag = dtag; end
      2: begin dtag = "R9"; ftag = "R6"; stag = "R8"; end
      default: begin dtag = "R9"; ftag = "R7"; stag = "R8"; end
    endcase
    if (c_port) dtag = "R1";
    check(dtag, int'(smp_mant), m_mant, "mantissa");
    check(dtag, int'(smp_exp), m_exp, "exponent");
    check(ftag, int'(new_sample), int'(m_new), "new_sample");
    check(stag, int'(phase_step), int'(m_step), "phase_step");
  endtask

  logic [31:0] lfsr = 32'h1ACE_5EED;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // enable pattern: runs of random length so levels persist across clocks
  int run_left = 0;
  bit run_val = 0;

  task automatic drive_cycle();
    lfsr = nxt(lfsr);
    a_mant = lfsr[13:0];
    a_exp  = lfsr[16:14];
    b_mant = ~lfsr[30:17];
    b_exp  = lfsr[31:29] ^ 3'b101;
    if (run_left == 0) begin
      run_val  = ~run_val;
      run_left = 1 + int'(lfsr[20:18]);
    end
    run_left--;
    a_en = run_val;
    b_en = lfsr[5] ^ run_val ? run_val : ~run_val;
  endtask

  task automatic run_phase(input int mode, input bit port, input int n);
    qual_mode  = mode[1:0];
    port_b_sel = port;
    for (int i = 0; i < n; i++) begin
      drive_cycle();
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    // R10: reset state, with enable high held through reset
    a_en = 1'b1;
    a_mant = 14'h0ABC; a_exp = 3'd5;
    repeat (3) @(negedge clk);
    check("R10", int'(smp_mant), 0, "reset mantissa");
    check("R10", int'(new_sample), 0, "reset new_sample");
    check("R10", int'(phase_step), 0, "reset phase_step");
    rst = 1'b0;
    // R10: first edge after reset in mode 2 with enable high is a rise
    @(negedge clk);
    check("R10", int'(new_sample), 1, "first rise after reset");
    check("R10", int'(smp_mant), 14'h0ABC, "first rise mantissa");
    compare_all();
    // R10: mode 3 needs a high level before a fall counts
    rst = 1'b1; qual_mode = 2'b11; a_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10", int'(new_sample), 0, "no fall without prior high");
    compare_all();

    run_phase(0, 0, 300);   // R2 R3
    run_phase(0, 1, 200);   // R1
    run_phase(1, 0, 300);   // R4 R5
    run_phase(1, 1, 200);   // R1
    run_phase(2, 0, 400);   // R6 R8 R9
    run_phase(3, 0, 400);   // R7 R8 R9
    run_phase(2, 1, 200);
    run_phase(3, 1, 200);
    for (int k = 0; k < 8; k++) run_phase(k % 4, k[0], 60);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule